// File: doc/BRIEF.md
# I2C Bus-Clear Pulse Sequencer

This block frees an I2C bus that a slave is holding by keeping SDA low. That situation arises when a reset cuts a transfer short. A single-cycle start request hands both bus pins to the sequencer and away from the normal I2C controller. The sequencer first lets both lines float high for one phase. It then pulls SCL low and releases it nine times. Each low phase and each high phase lasts one phase time, about 10 microseconds by default. The slave can clock out whatever it was sending during these pulses and then let go of SDA.

The lines are only ever pulled low or left floating, as open-drain drives require. SDA is never pulled by the sequencer, so the recovery creates no START or STOP condition. The train runs every time it is requested, because SDA alone does not show reliably whether the bus is blocked. After the last high phase the pins go back to the controller. A one-cycle done pulse then marks the end of the recovery.

The phase length in clock cycles is computed from a clock-frequency parameter and a phase-time parameter. The start, busy, done and pin-ownership signals are plain level or pulse control signals.

Top module: `bus_unjam`

## Requirements
- R1: When `start_i` is high while the block is idle, `busy_o` and `own_o` are high in the next cycle.
- R2: For the first P cycles of busy (the settle phase), neither pad drive enable is asserted, so both lines float high.
- R3: After the settle phase, `pad_scl_oe_o` (1 = pull SCL low) forms exactly nine pulses. Each pulse is P cycles asserted followed by P cycles released. Every pulse begins with the low half, so the train ends with SCL released.
- R4: P equals CLK_HZ × PHASE_US / 1,000,000 cycles, with a minimum of 1, and the whole recovery keeps `busy_o` high for exactly 19·P cycles.
- R5: While `own_o` is high, `pad_sda_oe_o` is 0 and the controller drive requests `ctl_scl_oe_i` and `ctl_sda_oe_i` have no effect on the pads.
- R6: While `own_o` is low, `pad_scl_oe_o` equals `ctl_scl_oe_i` and `pad_sda_oe_o` equals `ctl_sda_oe_i`. `own_o` falls in the first cycle after the last high phase.
- R7: `done_o` is high for exactly one cycle, the first cycle in which `busy_o` is low after a recovery.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored. The running train keeps its nine pulses and its 19·P-cycle length.
- R9: After reset, `busy_o`, `done_o` and `own_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a recovery (honoured only when idle) |
| ctl_scl_oe_i | input | 1 | Normal controller's SCL pull-low request |
| ctl_sda_oe_i | input | 1 | Normal controller's SDA pull-low request |
| busy_o | output | 1 | Recovery in progress |
| done_o | output | 1 | One-cycle pulse at the end of a recovery |
| own_o | output | 1 | Pin ownership: 1 = sequencer drives the pads |
| pad_scl_oe_o | output | 1 | Open-drain SCL pad enable (1 = pull low) |
| pad_sda_oe_o | output | 1 | Open-drain SDA pad enable (1 = pull low) |

## Verification
The assertions assume that `start_i` and the controller requests are synchronous to `clk` and stable across each edge. They also assume that the controller requests may take any value at any time, since the block must ignore them while it owns the pins. The bench drives every input just after the falling edge and holds both controller requests high for the whole recovery, so that a leak through the mux shows up at the pads. It repeats the recovery once with no extra start and once with a stray start placed on each busy cycle in turn. This covers every phase boundary with the ignored request.

// File: rtl/bus_unjam_pkg.sv
package bus_unjam_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_LOW    = 2'd2,
    ST_HIGH   = 2'd3
  } unjam_state_t;

  function automatic int unsigned phase_cycles(input longint unsigned clk_hz,
                                               input longint unsigned phase_us);
    longint unsigned raw;
    raw = (clk_hz * phase_us) / 64'd1000000;
    return (raw < 1) ? 1 : int'(raw);
  endfunction
endpackage

// File: rtl/unjam_phase_timer.sv
module unjam_phase_timer #(
  parameter int unsigned PHASE_CYC = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int unsigned TW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(PHASE_CYC - 1);

  logic [TW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (restart || !run || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + TW'(1);
    end
  end
endmodule

// File: rtl/unjam_pulse_count.sv
module unjam_pulse_count #(
  parameter int unsigned PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned PW = $clog2(PULSES + 1);
  localparam logic [PW-1:0] FINAL = PW'(PULSES - 1);

  logic [PW-1:0] count;

  assign last = (count == FINAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc) begin
      count <= count + PW'(1);
    end
  end
endmodule

// File: rtl/unjam_ctrl.sv
module unjam_ctrl
  import bus_unjam_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic last_pulse,
  output logic busy,
  output logic done,
  output logic scl_pull,
  output logic timer_restart,
  output logic pulse_clr,
  output logic pulse_inc
);
  unjam_state_t state, state_nx;
  logic         finish;

  always_comb begin
    state_nx      = state;
    timer_restart = 1'b0;
    pulse_clr     = 1'b0;
    pulse_inc     = 1'b0;
    finish        = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_nx      = ST_SETTLE;
          timer_restart = 1'b1;
          pulse_clr     = 1'b1;
        end
      end
      ST_SETTLE: if (tick) state_nx = ST_LOW;
      ST_LOW:    if (tick) state_nx = ST_HIGH;
      ST_HIGH: begin
        if (tick) begin
          pulse_inc = 1'b1;
          if (last_pulse) begin
            state_nx = ST_IDLE;
            finish   = 1'b1;
          end else begin
            state_nx = ST_LOW;
          end
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= finish;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign scl_pull = (state == ST_LOW);
endmodule

// File: rtl/unjam_pad_mux.sv
module unjam_pad_mux (
  input  logic own,
  input  logic seq_scl_oe,
  input  logic seq_sda_oe,
  input  logic ctl_scl_oe,
  input  logic ctl_sda_oe,
  output logic pad_scl_oe,
  output logic pad_sda_oe
);
  always_comb begin
    if (own) begin
      pad_scl_oe = seq_scl_oe;
      pad_sda_oe = seq_sda_oe;
    end else begin
      pad_scl_oe = ctl_scl_oe;
      pad_sda_oe = ctl_sda_oe;
    end
  end
endmodule

// File: rtl/bus_unjam.sv
module bus_unjam
  import bus_unjam_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 250_000_000,
  parameter int unsigned PHASE_US = 10,
  parameter int unsigned PULSES   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ctl_scl_oe_i,
  input  logic ctl_sda_oe_i,
  output logic busy_o,
  output logic done_o,
  output logic own_o,
  output logic pad_scl_oe_o,
  output logic pad_sda_oe_o
);
  localparam int unsigned PHASE_CYC = phase_cycles(CLK_HZ, PHASE_US);

  logic tick, last_pulse, busy, scl_pull;
  logic timer_restart, pulse_clr, pulse_inc;

  unjam_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start_i),
    .tick          (tick),
    .last_pulse    (last_pulse),
    .busy          (busy),
    .done          (done_o),
    .scl_pull      (scl_pull),
    .timer_restart (timer_restart),
    .pulse_clr     (pulse_clr),
    .pulse_inc     (pulse_inc)
  );

  unjam_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (timer_restart),
    .run     (busy),
    .tick    (tick)
  );

  unjam_pulse_count #(.PULSES(PULSES)) u_pulses (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (pulse_clr),
    .inc   (pulse_inc),
    .last  (last_pulse)
  );

  unjam_pad_mux u_mux (
    .own        (busy),
    .seq_scl_oe (scl_pull),
    .seq_sda_oe (1'b0),
    .ctl_scl_oe (ctl_scl_oe_i),
    .ctl_sda_oe (ctl_sda_oe_i),
    .pad_scl_oe (pad_scl_oe_o),
    .pad_sda_oe (pad_sda_oe_o)
  );

  assign busy_o = busy;
  assign own_o  = busy;
endmodule

// File: rtl/bus_unjam_checker.sv
module bus_unjam_checker (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic ctl_scl_oe_i,
  input logic ctl_sda_oe_i,
  input logic busy_o,
  input logic done_o,
  input logic own_o,
  input logic pad_scl_oe_o,
  input logic pad_sda_oe_o
);
  a_r1_start_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && own_o));

  a_r5_sda_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    own_o |-> !pad_sda_oe_o);

  a_r6_pads_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !own_o |-> (pad_scl_oe_o == ctl_scl_oe_i && pad_sda_oe_o == ctl_sda_oe_i));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  a_r3_ends_released: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !$past(pad_scl_oe_o));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
endmodule

bind bus_unjam bus_unjam_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .ctl_scl_oe_i (ctl_scl_oe_i),
  .ctl_sda_oe_i (ctl_sda_oe_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .own_o        (own_o),
  .pad_scl_oe_o (pad_scl_oe_o),
  .pad_sda_oe_o (pad_sda_oe_o)
);

// File: tb/bus_unjam_tb.sv
`timescale 1ns/1ps
module bus_unjam_tb;
  localparam int unsigned CLK_HZ   = 400_000;
  localparam int unsigned PHASE_US = 10;
  localparam int P     = (CLK_HZ * PHASE_US) / 1000000;
  localparam int TOTAL = 19 * P;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic ctl_scl_oe_i = 1'b0;
  logic ctl_sda_oe_i = 1'b0;
  logic busy_o, done_o, own_o, pad_scl_oe_o, pad_sda_oe_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bus_unjam #(.CLK_HZ(CLK_HZ), .PHASE_US(PHASE_US)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .ctl_scl_oe_i(ctl_scl_oe_i), .ctl_sda_oe_i(ctl_sda_oe_i),
    .busy_o(busy_o), .done_o(done_o), .own_o(own_o),
    .pad_scl_oe_o(pad_scl_oe_o), .pad_sda_oe_o(pad_sda_oe_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_seq(input int stray_at);
    int busy_cnt = 0, scl_bad = 0, sda_bad = 0, rises = 0, own_bad = 0;
    int settle_bad = 0, done_cnt = 0;
    bit prev_scl = 1'b0;
    bit first_busy = 1'b0;
    @(negedge clk);
    start_i = 1'b1;
    ctl_scl_oe_i = 1'b1;
    ctl_sda_oe_i = 1'b1;
    for (int j = 1; j <= TOTAL + 1; j++) begin
      @(negedge clk);
      if (j == 1) first_busy = busy_o;
      if (busy_o) busy_cnt++;
      if (done_o) done_cnt++;
      if (own_o != busy_o) own_bad++;
      if (j <= TOTAL) begin
        bit exp_scl;
        exp_scl = (((j - 1) / P) % 2) == 1;
        if (pad_scl_oe_o != exp_scl) scl_bad++;
        if (pad_sda_oe_o) sda_bad++;
        if (j <= P && (pad_scl_oe_o || pad_sda_oe_o)) settle_bad++;
        if (pad_scl_oe_o && !prev_scl) rises++;
        prev_scl = pad_scl_oe_o;
      end else begin
        check(!own_o && pad_scl_oe_o == 1'b1 && pad_sda_oe_o == 1'b1, "R6 pads return",
              int'(own_o), 0);
        check(done_o == 1'b1 && busy_o == 1'b0, "R7 done at end", int'(done_o), 1);
      end
      start_i = (j == stray_at);
    end
    start_i = 1'b0;
    ctl_scl_oe_i = 1'b0;
    ctl_sda_oe_i = 1'b0;
    @(negedge clk);
    check(!done_o && !busy_o, "R7 done single", int'(done_o), 0);
    check(first_busy, "R1 start claims", int'(first_busy), 1);
    check(own_bad == 0, "R1 own with busy", own_bad, 0);
    check(settle_bad == 0, "R2 settle released", settle_bad, 0);
    check(scl_bad == 0, "R3 scl pattern", scl_bad, 0);
    check(rises == 9, "R3 pulse count", rises, 9);
    check(busy_cnt == TOTAL, stray_at > 0 ? "R8 stray start length" : "R4 busy length",
          busy_cnt, TOTAL);
    check(sda_bad == 0, "R5 sda untouched", sda_bad, 0);
    check(done_cnt == 1, "R7 done count", done_cnt, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !own_o, "R9 reset state",
          int'({busy_o, done_o, own_o}), 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      ctl_scl_oe_i = c[0];
      ctl_sda_oe_i = c[1];
      #1;
      check(pad_scl_oe_o == c[0] && pad_sda_oe_o == c[1], "R6 idle passthrough",
            int'({pad_sda_oe_o, pad_scl_oe_o}), c);
    end
    ctl_scl_oe_i = 1'b0;
    ctl_sda_oe_i = 1'b0;
    check(P == 4, "R4 phase length", P, 4);
    run_seq(0);
    for (int k = 1; k <= TOTAL; k++) run_seq(k);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule